// File: doc/BRIEF.md
# LED Drive Dimming and Flash/Blink Gate

This block produces the one-bit drive enable that switches the column current of an eight-digit dot-matrix LED display. Two effects are combined in it. A brightness code picks one of eight duty cycles, from full on down to fully blank. A slow square wave, made by dividing the display clock, can switch the drive off for half of each period. The brightness setting changes only how long the drive is on within each period. It never changes the drive level, because the output is a single enable bit.

The square wave can gate a single digit or the whole display. A digit is gated when the flash function is enabled and that digit's bit in the per-digit flash mask is set. All digits are gated when the blink function is enabled, and blink takes priority over flash. The caller supplies the index of the digit being scanned and reads the enable for that digit in the same cycle. Reset restarts every internal counter. Several displays that share a clock and a reset therefore flash and blink in phase.

Top module: `led_dim_gate`

## Requirements
- R1: Each brightness code gives a fixed number of on-steps in every 15-clock sub-cycle. Codes 0,1,2,3,4,5,6,7 give 15,12,8,6,4,3,2,0 on-steps, which is about 100,80,53,40,27,20,13,0 percent.
- R2: Brightness code 7 (binary 111) keeps the drive enable low in every cycle.
- R3: The gating wave has a period of exactly 28,672 clocks. It is high for the first 14,336 clocks after reset and low for the next 14,336.
- R4: When the flash function is enabled and the mask bit of the current digit is 1 (bit i of the mask belongs to digit i), the drive enable is forced low whenever the wave is low.
- R5: When the flash function is enabled, a digit whose mask bit is 0 keeps its normal duty cycle in both halves of the wave.
- R6: When the flash function is disabled, the flash mask has no effect on the drive enable.
- R7: When the blink function is enabled, every digit is forced low while the wave is low. This holds whatever the flash function and the mask are set to.
- R8: Reset (active low, asynchronous) clears the sub-cycle counter and the wave divider. Right after reset the wave is high and the sub-cycle is at step 0.
- R9: Within a sub-cycle the on-steps come first: the enable is high for steps 0 up to the on-step count minus 1, and low for the remaining steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sub-cycle counter and the wave divider |
| brightCode | input | 3 | Brightness level, 0 = full on, 7 = blank |
| flashEn | input | 1 | Enables per-digit flashing from the mask |
| blinkEn | input | 1 | Enables whole-display blinking; takes priority over flashing |
| flashMask | input | 8 | One flash bit per digit; bit i belongs to digit i |
| digitIdx | input | 3 | Index of the digit being driven this cycle |
| driveEn | output | 1 | Column drive enable for the current digit |

## Verification
The assertions check several rules on every cycle. The sub-cycle counter must step by one and wrap after 15 steps. The wave must fall at mid-period and rise again as the divider wraps. A blank code, or an active blink while the wave is low, must always hold the enable low. With full brightness and no gating, the enable must always be high. Other behaviour can only be shown by the bench's scenarios: the exact on-step count of each code, the placement of the on-steps at the start of the sub-cycle, per-digit mask selection, and whether the wave edges fall on the right clock counts, both after power-up and after a reset in the middle of a period.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

  localparam int unsigned DIM_CODE_W   = 3;
  localparam int unsigned SUB_STEPS    = 15;
  localparam int unsigned SUB_W        = $clog2(SUB_STEPS);
  localparam int unsigned WAVE_PERIOD  = 28672;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic [SUB_W-1:0] subStep;
    logic             waveHigh;
  } dim_strobe_t;

  // Number of on-steps per sub-cycle for each brightness code.
  function automatic logic [SUB_W-1:0] onStepsFor(input logic [DIM_CODE_W-1:0] code);
    logic [SUB_W-1:0] steps;
    case (code)
      3'd0:    steps = SUB_W'(15);
      3'd1:    steps = SUB_W'(12);
      3'd2:    steps = SUB_W'(8);
      3'd3:    steps = SUB_W'(6);
      3'd4:    steps = SUB_W'(4);
      3'd5:    steps = SUB_W'(3);
      3'd6:    steps = SUB_W'(2);
      default: steps = SUB_W'(0);
    endcase
    return steps;
  endfunction

endpackage

// File: rtl/led_dim_ctrl.sv
module led_dim_ctrl
  import led_dim_pkg::*;
#(
  parameter int unsigned PERIOD = WAVE_PERIOD
) (
  input  logic        clk,
  input  logic        rst_n,
  output dim_strobe_t strb
);

  localparam int unsigned DIV_W = $clog2(PERIOD);
  localparam int unsigned HALF  = PERIOD / 2;

  logic [SUB_W-1:0] subCnt;
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subCnt <= '0;
    end else if (subCnt == SUB_W'(SUB_STEPS - 1)) begin
      subCnt <= '0;
    end else begin
      subCnt <= subCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
    end else if (divCnt == DIV_W'(PERIOD - 1)) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strb.subStep  = subCnt;
    strb.waveHigh = (divCnt < DIV_W'(HALF));
  end

  // R1: the sub-cycle steps by one and wraps after the last step
  p_sub_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.subStep != SUB_W'(SUB_STEPS - 1)) |=> (strb.subStep == $past(strb.subStep) + 1'b1));
  p_sub_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.subStep == SUB_W'(SUB_STEPS - 1)) |=> (strb.subStep == '0));

  // R3: the wave falls at mid-period and rises when the divider wraps
  p_wave_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (divCnt == DIV_W'(HALF - 1)) |=> !strb.waveHigh);
  p_wave_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (divCnt == DIV_W'(PERIOD - 1)) |=> (strb.waveHigh && divCnt == '0));

endmodule

// File: rtl/led_dim_dp.sv
module led_dim_dp
  import led_dim_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dim_strobe_t           strb,
  input  logic [DIM_CODE_W-1:0] brightCode,
  input  logic                  flashEn,
  input  logic                  blinkEn,
  input  logic [NUM_DIGITS-1:0] flashMask,
  input  logic [DIG_W-1:0]      digitIdx,
  output logic                  driveEn
);

  logic [SUB_W-1:0] onSteps;
  logic             pwmOn;
  logic             maskBit;
  logic             gateSel;

  always_comb begin
    onSteps = onStepsFor(brightCode);
    pwmOn   = (strb.subStep < onSteps);
    maskBit = flashMask[digitIdx];
    gateSel = blinkEn | (flashEn & maskBit);
    driveEn = pwmOn & (strb.waveHigh | ~gateSel);
  end

  // R2: the blank code never drives
  p_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (brightCode == 3'd7) |-> !driveEn);

  // R7: blink holds every digit off while the wave is low
  p_blink_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blinkEn && !strb.waveHigh) |-> !driveEn);

  // R6: full brightness without gating drives on every cycle
  p_full_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brightCode == 3'd0 && !blinkEn && !flashEn) |-> driveEn);

endmodule

// File: rtl/led_dim_gate.sv
module led_dim_gate
  import led_dim_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned PERIOD     = WAVE_PERIOD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] brightCode,
  input  logic       flashEn,
  input  logic       blinkEn,
  input  logic [7:0] flashMask,
  input  logic [2:0] digitIdx,
  output logic       driveEn
);

  dim_strobe_t strb;

  led_dim_ctrl #(.PERIOD(PERIOD)) ctrl_i (
    .clk  (clk),
    .rst_n(rst_n),
    .strb (strb)
  );

  led_dim_dp #(.NUM_DIGITS(NUM_DIGITS)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .brightCode(brightCode),
    .flashEn   (flashEn),
    .blinkEn   (blinkEn),
    .flashMask (flashMask),
    .digitIdx  (digitIdx),
    .driveEn   (driveEn)
  );

endmodule

// File: tb/led_dim_gate_tb_top.sv
module led_dim_gate_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] brightCode = '0;
  logic       flashEn = 1'b0;
  logic       blinkEn = 1'b0;
  logic [7:0] flashMask = '0;
  logic [2:0] digitIdx = '0;
  logic       driveEn;

  int nChecks = 0;
  int nFails  = 0;
  int n       = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  led_dim_gate dut_i (
    .clk(clk), .rst_n(rst_n), .brightCode(brightCode), .flashEn(flashEn),
    .blinkEn(blinkEn), .flashMask(flashMask), .digitIdx(digitIdx), .driveEn(driveEn)
  );

  // Vector: {code[23:21], flashEn[20], blinkEn[19], mask[18:11], digit[10:8],
  //          on-steps in high half [7:4], on-steps in low half [3:0]}
  localparam int NV = 10;
  localparam logic [23:0] VECS [NV] = '{
    {3'd0, 1'b0, 1'b0, 8'h00, 3'd0, 4'd15, 4'd15},  // R1 full
    {3'd1, 1'b0, 1'b0, 8'h00, 3'd4, 4'd12, 4'd12},  // R1
    {3'd3, 1'b1, 1'b0, 8'h08, 3'd3, 4'd6,  4'd0 },  // R4 masked digit
    {3'd4, 1'b1, 1'b0, 8'h08, 3'd2, 4'd4,  4'd4 },  // R5 unmasked digit
    {3'd5, 1'b0, 1'b0, 8'hFF, 3'd5, 4'd3,  4'd3 },  // R6 mask ignored
    {3'd6, 1'b0, 1'b1, 8'h00, 3'd1, 4'd2,  4'd0 },  // R7 blink
    {3'd0, 1'b1, 1'b1, 8'h00, 3'd6, 4'd15, 4'd0 },  // R7 overrides flash
    {3'd7, 1'b0, 1'b0, 8'h00, 3'd0, 4'd0,  4'd0 },  // R2 blank
    {3'd2, 1'b1, 1'b0, 8'h80, 3'd7, 4'd8,  4'd0 },  // R4 top digit
    {3'd1, 1'b1, 1'b0, 8'h7F, 3'd7, 4'd12, 4'd12}   // R5
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    n++;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
  endtask

  task automatic setIn(input logic [2:0] c, input logic fe, input logic be,
                       input logic [7:0] m, input logic [2:0] d);
    brightCode = c; flashEn = fe; blinkEn = be; flashMask = m; digitIdx = d;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at n=%0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  task automatic walkVectors(input bit lowHalf);
    for (int i = 0; i < NV; i++) begin
      int ones;
      setIn(VECS[i][23:21], VECS[i][20], VECS[i][19], VECS[i][18:11], VECS[i][10:8]);
      #1;
      ones = 0;
      for (int s = 0; s < 15; s++) begin
        ones += int'(driveEn);
        step();
      end
      chk($sformatf("vector %0d (%s half)", i, lowHalf ? "low" : "high"), ones,
          lowHalf ? int'(VECS[i][3:0]) : int'(VECS[i][7:4]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R8: reset state, counters at zero and wave high
    repeat (2) @(negedge clk);
    setIn(3'd0, 1'b0, 1'b1, 8'h00, 3'd0);
    #1 chk("R8 reset state full on", int'(driveEn), 1);
    setIn(3'd7, 1'b0, 1'b0, 8'h00, 3'd0);
    #1 chk("R2 reset state blank", int'(driveEn), 0);

    // Table walk in both halves of the wave (R1 R2 R4 R5 R6 R7)
    doReset();
    walkVectors(1'b0);
    while (n < 14336) step();
    walkVectors(1'b1);

    // R9: on-steps placed at the start of the sub-cycle
    doReset();
    setIn(3'd2, 1'b0, 1'b0, 8'h00, 3'd0);
    #1;
    for (int s = 0; s < 15; s++) begin
      chk($sformatf("R9 step %0d", s), int'(driveEn), (s < 8) ? 1 : 0);
      step();
    end

    // R3: wave edges at exact clock counts
    doReset();
    setIn(3'd0, 1'b0, 1'b1, 8'h00, 3'd0);
    #1;
    while (n < 14335) step();
    chk("R3 last high clock", int'(driveEn), 1);
    step();
    chk("R3 first low clock", int'(driveEn), 0);
    while (n < 28671) step();
    chk("R3 last low clock", int'(driveEn), 0);
    step();
    chk("R3 period wrap", int'(driveEn), 1);

    // R8: reset in the middle of a low half restarts the phase
    while (n < 28672 + 14336 + 100) step();
    chk("R8 low before resync", int'(driveEn), 0);
    #1 rst_n = 1'b0;
    #1 chk("R8 high during reset", int'(driveEn), 1);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (n < 14335) step();
    chk("R8 high until half after resync", int'(driveEn), 1);
    step();
    chk("R8 low at half after resync", int'(driveEn), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule